// File: doc/BRIEF.md
# Hypervisor CSR Access Permission Checker

This block sits in the CSR unit of a core that implements the hypervisor extension. For each CSR access request it decides whether the access may proceed, or whether it must trap with an illegal-instruction or a virtual-instruction exception. It covers three groups of registers:

- the indirect-access select registers and their data aliases, in both the supervisor and the VS-prefixed forms;
- the supervisor and hypervisor context registers;
- the upper half of the hypervisor exception-delegation register, which exists only on 32-bit configurations.

It also applies the generic privilege and read-only rules to every address. The CSR storage, the datapath and trap entry are handled elsewhere.

The decision is combinational, and it is registered one cycle after a valid request. The rules are applied in a fixed order:

1. Existence of the upper delegation register.
2. State-enable gating from the machine and hypervisor enable words.
3. The rule that blocks direct access to VS-prefixed registers in virtualized mode.
4. The check for a missing indirect target.
5. The generic privilege check.

The first rule that fires decides the result.

Top module: `hv_csr_access_check`

## Requirements
- R1: `rsp_valid` is 1 exactly in the cycle after a cycle with `req_valid`=1. While `rsp_valid` is 0, both exception outputs are 0. A synchronous reset (`rst_n`=0) clears all three outputs.
- R2: `exc_illegal` and `exc_virtual` are never 1 together. {0,0} means the access is allowed.
- R3: Indirect group: select register 0x150, aliases 0x151, 0x152, 0x153, 0x155, 0x156 and 0x157, and the VS forms at 0x250 to 0x257 with the same offsets. This gating applies when `stateen_en`=1 and `priv`≠3. If `menable_word` bit 60 is 0, the access is illegal. Otherwise, if `virt`=1 and `henable_word` bit 60 is 0, the access is virtual.
- R4: Address 0x5A8, when `stateen_en`=1 and `priv`≠3: if `menable_word` bit 57 is 0, the access is illegal. Otherwise, if `virt`=1 and `henable_word` bit 57 is 0, the access is virtual.
- R5: Address 0x6A8, when `stateen_en`=1 and `priv`≠3: if `menable_word` bit 57 is 0, the access is illegal. No hypervisor enable bit is consulted for this address.
- R6: Address 0x612 is illegal at any privilege when `xlen32`=0. When `xlen32`=1, `stateen_en`=1 and `priv`≠3, it is illegal if `menable_word` bit 56 is 0.
- R7: With `priv`=3 (M), or with `stateen_en`=0, no state-enable bit has any effect.
- R8: Take `virt` as 1 only when `priv`≠3. With `virt`=1, any access to 0x250 or its aliases is virtual. With `virt`=1 and `priv`=0 (U), any access to 0x150 or its aliases is virtual.
- R9: An access to an alias register (not a select register) that passes R3 and R8 is illegal when `ind_target_ok`=0, whatever the value of `virt`.
- R10: Generic rule, with required level = address bits [9:8]. The effective level is 3 in M, 2 in S with `virt`=0, 1 in S with `virt`=1, and 0 in U. If the effective level is below the required level, the result is virtual when `virt`=1 and the required level is at most 2, and illegal otherwise. A write (`csr_write`=1) to an address with bits [11:10]=3 is illegal.
- R11: The checks take priority in this order: R6 existence, then R3 to R6 gating, then R8, then R9, then R10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Access request present this cycle |
| csr_addr | input | 12 | CSR address of the access |
| csr_write | input | 1 | Access writes the CSR |
| priv | input | 2 | Current privilege: 0 U, 1 S, 3 M |
| virt | input | 1 | Virtualization mode active |
| xlen32 | input | 1 | Core configured for 32-bit registers |
| stateen_en | input | 1 | State-enable gating implemented |
| menable_word | input | 64 | Machine state-enable word 0 |
| henable_word | input | 64 | Hypervisor state-enable word 0 |
| ind_target_ok | input | 1 | Current select value maps to an implemented register |
| rsp_valid | output | 1 | Decision valid, one cycle after request |
| exc_illegal | output | 1 | Access raises illegal-instruction |
| exc_virtual | output | 1 | Access raises virtual-instruction |

## Verification
The stimulus sweeps each register group across U, S and M, with `virt` both set and clear. For each group, the enable bits are cleared one at a time, which separates the machine-word gate from the hypervisor-word gate and from the generic level rule. Pairs of vectors differ only in a bit of lower precedence: a missing target together with a VS direct access, both enable words clear, or 0x612 with a bad register width in M-mode. These pairs show that the higher-ranked rule wins. Directed steps cover reset with a request pending, an idle cycle after a burst, and M-mode or disabled gating with every enable bit clear.

// File: rtl/hvchk_pkg.sv
// Shared types and constants for the hypervisor CSR access checker.
// Assumes a 12-bit CSR address space and the standard 2-bit privilege code.
package hvchk_pkg;

    localparam int CSR_AW = 12;

    typedef enum logic [2:0] {
        CLS_OTHER,
        CLS_SSEL,
        CLS_SALIAS,
        CLS_VSSEL,
        CLS_VSALIAS,
        CLS_SCTX,
        CLS_HCTX,
        CLS_DLGH
    } csr_cls_e;

    localparam logic [1:0] LVL_U = 2'd0;
    localparam logic [1:0] LVL_S = 2'd1;
    localparam logic [1:0] LVL_H = 2'd2;
    localparam logic [1:0] LVL_M = 2'd3;

    localparam logic [CSR_AW-1:0] ADR_SSEL  = 12'h150;
    localparam logic [CSR_AW-1:0] ADR_VSSEL = 12'h250;
    localparam logic [CSR_AW-1:0] ADR_SCTX  = 12'h5A8;
    localparam logic [CSR_AW-1:0] ADR_HCTX  = 12'h6A8;
    localparam logic [CSR_AW-1:0] ADR_DLGH  = 12'h612;

    localparam int N_ALIAS = 6;

    // Offsets of the alias registers above their select register.
    function automatic logic [3:0] alias_off(input int idx);
        case (idx)
            0:       return 4'd1;
            1:       return 4'd2;
            2:       return 4'd3;
            3:       return 4'd5;
            4:       return 4'd6;
            default: return 4'd7;
        endcase
    endfunction

endpackage

// File: rtl/hvchk_decode.sv
// Address classifier: maps a CSR address to the register group it belongs to.
// Assumes exact address matches; any address outside the groups is CLS_OTHER.
module hvchk_decode
    import hvchk_pkg::*;
#(
    parameter int NA = N_ALIAS
) (
    input  logic [CSR_AW-1:0] addr,
    output csr_cls_e          cls
);

    logic [NA-1:0] s_hit;
    logic [NA-1:0] v_hit;

    // One comparator per alias offset, for each of the two select bases.
    for (genvar i = 0; i < NA; i++) begin : g_alias
        localparam logic [CSR_AW-1:0] OFF = CSR_AW'(alias_off(i));
        assign s_hit[i] = (addr == ADR_SSEL + OFF);
        assign v_hit[i] = (addr == ADR_VSSEL + OFF);
    end

    // Priority-free classification (all matches are mutually exclusive).
    always_comb begin
        cls = CLS_OTHER;
        if (addr == ADR_SSEL)       cls = CLS_SSEL;
        else if (|s_hit)            cls = CLS_SALIAS;
        else if (addr == ADR_VSSEL) cls = CLS_VSSEL;
        else if (|v_hit)            cls = CLS_VSALIAS;
        else if (addr == ADR_SCTX)  cls = CLS_SCTX;
        else if (addr == ADR_HCTX)  cls = CLS_HCTX;
        else if (addr == ADR_DLGH)  cls = CLS_DLGH;
    end

endmodule

// File: rtl/hvchk_stateen_gate.sv
// State-enable gate: applies machine and hypervisor enable bits to the
// indirect group, the context registers and the upper delegation register.
// Assumes the caller has already qualified virt with a non-machine privilege.
module hvchk_stateen_gate
    import hvchk_pkg::*;
(
    input  csr_cls_e   cls,
    input  logic [1:0] priv,
    input  logic       eff_virt,
    input  logic       stateen_en,
    input  logic       m_ind,
    input  logic       m_ctx,
    input  logic       m_p113,
    input  logic       h_ind,
    input  logic       h_ctx,
    output logic       gate_ill,
    output logic       gate_vir
);

    logic active;
    logic is_ind;

    assign active = stateen_en && (priv != LVL_M);
    assign is_ind = (cls == CLS_SSEL) || (cls == CLS_SALIAS) ||
                    (cls == CLS_VSSEL) || (cls == CLS_VSALIAS);

    // Machine-word check first, hypervisor-word check only if it passes.
    always_comb begin
        gate_ill = 1'b0;
        gate_vir = 1'b0;
        if (active) begin
            if (is_ind) begin
                if (!m_ind)                 gate_ill = 1'b1;
                else if (eff_virt && !h_ind) gate_vir = 1'b1;
            end else if (cls == CLS_SCTX) begin
                if (!m_ctx)                 gate_ill = 1'b1;
                else if (eff_virt && !h_ctx) gate_vir = 1'b1;
            end else if (cls == CLS_HCTX) begin
                if (!m_ctx)                 gate_ill = 1'b1;
            end else if (cls == CLS_DLGH) begin
                if (!m_p113)                gate_ill = 1'b1;
            end
        end
    end

endmodule

// File: rtl/hvchk_base_priv.sv
// Generic privilege rule: compares the effective level with the level in
// address bits [9:8] and rejects writes to read-only addresses.
// Assumes priv encodes U=0, S=1, M=3 and eff_virt is 0 in M-mode.
module hvchk_base_priv
    import hvchk_pkg::*;
(
    input  logic [3:0] addr_hi,
    input  logic       wr,
    input  logic [1:0] priv,
    input  logic       eff_virt,
    output logic       base_ill,
    output logic       base_vir
);

    logic [1:0] eff_lvl;
    logic [1:0] need_lvl;

    assign need_lvl = addr_hi[1:0];

    // HS-mode (S without virtualization) reaches hypervisor-level registers.
    always_comb begin
        case (priv)
            LVL_M:   eff_lvl = LVL_M;
            LVL_S:   eff_lvl = eff_virt ? LVL_S : LVL_H;
            default: eff_lvl = priv;
        endcase
    end

    // Level shortfall first, then the read-only write check.
    always_comb begin
        base_ill = 1'b0;
        base_vir = 1'b0;
        if (eff_lvl < need_lvl) begin
            if (eff_virt && need_lvl <= LVL_H) base_vir = 1'b1;
            else                               base_ill = 1'b1;
        end else if (wr && addr_hi[3:2] == 2'b11) begin
            base_ill = 1'b1;
        end
    end

endmodule

// File: rtl/hv_csr_access_check.sv
// Top of the hypervisor CSR access checker. Combines the existence, gating,
// virtualized-direct, missing-target and generic rules in fixed precedence
// and registers the one-hot result one cycle after a valid request.
// Assumes the enable words are stable during the request cycle.
module hv_csr_access_check
    import hvchk_pkg::*;
#(
    parameter int SE_W      = 64,
    parameter int IND_BIT   = 60,
    parameter int CTX_BIT   = 57,
    parameter int P113_BIT  = 56
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [CSR_AW-1:0] csr_addr,
    input  logic              csr_write,
    input  logic [1:0]        priv,
    input  logic              virt,
    input  logic              xlen32,
    input  logic              stateen_en,
    input  logic [SE_W-1:0]   menable_word,
    input  logic [SE_W-1:0]   henable_word,
    input  logic              ind_target_ok,
    output logic              rsp_valid,
    output logic              exc_illegal,
    output logic              exc_virtual
);

    csr_cls_e cls;
    logic     eff_virt;
    logic     gate_ill, gate_vir;
    logic     base_ill, base_vir;
    logic     rule_vir;
    logic     is_alias;
    logic     nxt_ill, nxt_vir;
    logic     unused_se_bits;

    assign eff_virt = virt && (priv != LVL_M);
    assign is_alias = (cls == CLS_SALIAS) || (cls == CLS_VSALIAS);
    assign unused_se_bits = ^{menable_word, henable_word};

    hvchk_decode #(.NA(N_ALIAS)) u_dec (
        .addr (csr_addr),
        .cls  (cls)
    );

    hvchk_stateen_gate u_gate (
        .cls        (cls),
        .priv       (priv),
        .eff_virt   (eff_virt),
        .stateen_en (stateen_en),
        .m_ind      (menable_word[IND_BIT]),
        .m_ctx      (menable_word[CTX_BIT]),
        .m_p113     (menable_word[P113_BIT]),
        .h_ind      (henable_word[IND_BIT]),
        .h_ctx      (henable_word[CTX_BIT]),
        .gate_ill   (gate_ill),
        .gate_vir   (gate_vir)
    );

    hvchk_base_priv u_base (
        .addr_hi  (csr_addr[CSR_AW-1:CSR_AW-4]),
        .wr       (csr_write),
        .priv     (priv),
        .eff_virt (eff_virt),
        .base_ill (base_ill),
        .base_vir (base_vir)
    );

    // Virtualized direct-access rule for the indirect group.
    always_comb begin
        rule_vir = 1'b0;
        if (eff_virt) begin
            if (cls == CLS_VSSEL || cls == CLS_VSALIAS)
                rule_vir = 1'b1;
            else if ((cls == CLS_SSEL || cls == CLS_SALIAS) && priv == LVL_U)
                rule_vir = 1'b1;
        end
    end

    // Fixed-precedence merge of all rules into one decision.
    always_comb begin
        nxt_ill = 1'b0;
        nxt_vir = 1'b0;
        if (cls == CLS_DLGH && !xlen32) nxt_ill = 1'b1;
        else if (gate_ill)              nxt_ill = 1'b1;
        else if (gate_vir)              nxt_vir = 1'b1;
        else if (rule_vir)              nxt_vir = 1'b1;
        else if (is_alias && !ind_target_ok) nxt_ill = 1'b1;
        else begin
            nxt_ill = base_ill;
            nxt_vir = base_vir;
        end
    end

    // Response register: one cycle after a request, cleared when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid   <= 1'b0;
            exc_illegal <= 1'b0;
            exc_virtual <= 1'b0;
        end else begin
            rsp_valid   <= req_valid;
            exc_illegal <= req_valid && nxt_ill;
            exc_virtual <= req_valid && nxt_vir;
        end
    end

    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid); // R1
    AST_RSP_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid); // R1
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (!exc_illegal && !exc_virtual)); // R1
    AST_EXC_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({exc_illegal, exc_virtual})); // R2
    AST_DLGH_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && csr_addr == ADR_DLGH && !xlen32) |=> exc_illegal); // R6
    AST_VS_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && virt && priv != LVL_M && csr_addr == ADR_VSSEL &&
         (!stateen_en || menable_word[IND_BIT])) |=> exc_virtual); // R8
    AST_M_NO_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && priv == LVL_M && csr_addr == ADR_SCTX)
        |=> (!exc_illegal && !exc_virtual)); // R7

endmodule

// File: tb/sim_hv_csr_access_check.sv
`timescale 1ns/1ps
// Self-checking bench: a vector table walked by one loop, then directed tests.
module sim_hv_csr_access_check;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [11:0] csr_addr = 12'h000;
    logic        csr_write = 1'b0;
    logic [1:0]  priv = 2'd0;
    logic        virt = 1'b0;
    logic        xlen32 = 1'b0;
    logic        stateen_en = 1'b0;
    logic [63:0] menable_word = 64'd0;
    logic [63:0] henable_word = 64'd0;
    logic        ind_target_ok = 1'b0;
    logic        rsp_valid, exc_illegal, exc_virtual;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    hv_csr_access_check u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .csr_addr(csr_addr),
        .csr_write(csr_write), .priv(priv), .virt(virt), .xlen32(xlen32),
        .stateen_en(stateen_en), .menable_word(menable_word),
        .henable_word(henable_word), .ind_target_ok(ind_target_ok),
        .rsp_valid(rsp_valid), .exc_illegal(exc_illegal), .exc_virtual(exc_virtual)
    );

    // Vector: req[29:26] addr[25:14] wr[13] priv[12:11] v[10] x32[9] sen[8]
    // m{b60,b57,b56}[7:5] h{b60,b57}[4:3] tgt[2] exp{ill,vir}[1:0]
    localparam int NV = 32;
    localparam logic [29:0] VEC [NV] = '{
        {4'd3,  12'h150,1'b0,2'd1,1'b0,1'b1,1'b1,3'b000,2'b00,1'b1,2'b10}, // R3 m clear
        {4'd3,  12'h150,1'b0,2'd1,1'b1,1'b1,1'b1,3'b100,2'b00,1'b1,2'b01}, // R3 h clear
        {4'd8,  12'h150,1'b0,2'd1,1'b1,1'b1,1'b1,3'b100,2'b10,1'b1,2'b00}, // R8 VS ok
        {4'd8,  12'h250,1'b0,2'd1,1'b1,1'b1,1'b1,3'b100,2'b10,1'b1,2'b01}, // R8 VS direct
        {4'd8,  12'h150,1'b0,2'd0,1'b1,1'b1,1'b1,3'b100,2'b10,1'b1,2'b01}, // R8 VU
        {4'd10, 12'h150,1'b0,2'd0,1'b0,1'b1,1'b1,3'b100,2'b00,1'b1,2'b10}, // R10 U
        {4'd9,  12'h151,1'b0,2'd1,1'b0,1'b1,1'b1,3'b100,2'b00,1'b0,2'b10}, // R9
        {4'd11, 12'h251,1'b0,2'd1,1'b1,1'b1,1'b1,3'b100,2'b10,1'b0,2'b01}, // R11 R8 over R9
        {4'd10, 12'h251,1'b0,2'd1,1'b0,1'b1,1'b1,3'b100,2'b00,1'b1,2'b00}, // R10 HS ok
        {4'd9,  12'h251,1'b0,2'd1,1'b0,1'b1,1'b1,3'b100,2'b00,1'b0,2'b10}, // R9 v=0
        {4'd7,  12'h151,1'b0,2'd3,1'b0,1'b1,1'b1,3'b000,2'b00,1'b1,2'b00}, // R7 M
        {4'd7,  12'h150,1'b0,2'd1,1'b0,1'b1,1'b0,3'b000,2'b00,1'b1,2'b00}, // R7 off
        {4'd4,  12'h5A8,1'b0,2'd1,1'b0,1'b1,1'b1,3'b000,2'b00,1'b1,2'b10}, // R4 m
        {4'd4,  12'h5A8,1'b0,2'd1,1'b1,1'b1,1'b1,3'b010,2'b00,1'b1,2'b01}, // R4 h
        {4'd4,  12'h5A8,1'b0,2'd1,1'b1,1'b1,1'b1,3'b010,2'b01,1'b1,2'b00}, // R4 ok
        {4'd5,  12'h6A8,1'b0,2'd1,1'b0,1'b1,1'b1,3'b000,2'b00,1'b1,2'b10}, // R5 m
        {4'd5,  12'h6A8,1'b0,2'd1,1'b0,1'b1,1'b1,3'b010,2'b00,1'b1,2'b00}, // R5 no h
        {4'd10, 12'h6A8,1'b0,2'd1,1'b1,1'b1,1'b1,3'b010,2'b00,1'b1,2'b01}, // R10 VS->H
        {4'd6,  12'h612,1'b0,2'd1,1'b0,1'b0,1'b0,3'b000,2'b00,1'b1,2'b10}, // R6 width
        {4'd6,  12'h612,1'b0,2'd1,1'b0,1'b1,1'b1,3'b000,2'b00,1'b1,2'b10}, // R6 bit56
        {4'd6,  12'h612,1'b0,2'd1,1'b0,1'b1,1'b1,3'b001,2'b00,1'b1,2'b00}, // R6 ok
        {4'd6,  12'h612,1'b0,2'd3,1'b0,1'b0,1'b1,3'b111,2'b11,1'b1,2'b10}, // R6 M width
        {4'd10, 12'h612,1'b0,2'd1,1'b1,1'b1,1'b1,3'b001,2'b00,1'b1,2'b01}, // R10 VS
        {4'd10, 12'hC00,1'b1,2'd3,1'b0,1'b1,1'b0,3'b000,2'b00,1'b1,2'b10}, // R10 ro write
        {4'd10, 12'hC00,1'b0,2'd0,1'b0,1'b1,1'b0,3'b000,2'b00,1'b1,2'b00}, // R10 ro read
        {4'd10, 12'h300,1'b0,2'd1,1'b0,1'b1,1'b0,3'b000,2'b00,1'b1,2'b10}, // R10 M reg
        {4'd10, 12'h300,1'b0,2'd1,1'b1,1'b1,1'b0,3'b000,2'b00,1'b1,2'b10}, // R10 M reg V
        {4'd10, 12'h100,1'b0,2'd0,1'b1,1'b1,1'b0,3'b000,2'b00,1'b1,2'b01}, // R10 VU
        {4'd11, 12'h150,1'b0,2'd1,1'b1,1'b1,1'b1,3'b000,2'b00,1'b1,2'b10}, // R11 m over h
        {4'd11, 12'h152,1'b0,2'd1,1'b0,1'b1,1'b1,3'b000,2'b00,1'b0,2'b10}, // R11 gate first
        {4'd9,  12'h151,1'b0,2'd3,1'b0,1'b1,1'b1,3'b000,2'b00,1'b0,2'b10}, // R9 in M
        {4'd7,  12'h5A8,1'b0,2'd3,1'b0,1'b1,1'b1,3'b000,2'b00,1'b1,2'b00}  // R7 M ctx
    };

    task automatic check(input string tag, input logic [2:0] act, input logic [2:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: {rsp_valid,ill,vir} actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [29:0] v);
        csr_addr      = v[25:14];
        csr_write     = v[13];
        priv          = v[12:11];
        virt          = v[10];
        xlen32        = v[9];
        stateen_en    = v[8];
        menable_word  = 64'd0;
        henable_word  = 64'd0;
        menable_word[60] = v[7];
        menable_word[57] = v[6];
        menable_word[56] = v[5];
        henable_word[60] = v[4];
        henable_word[57] = v[3];
        ind_target_ok = v[2];
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        // R1: reset with a pending request keeps outputs clear
        req_valid = 1'b1;
        drive(VEC[0]);
        repeat (2) @(negedge clk);
        check("R1 reset", {rsp_valid, exc_illegal, exc_virtual}, 3'b000);
        rst_n = 1'b1;
        req_valid = 1'b0;
        @(negedge clk);
        check("R1 idle", {rsp_valid, exc_illegal, exc_virtual}, 3'b000);

        // Table walk, back-to-back requests
        for (int i = 0; i < NV; i++) begin
            drive(VEC[i]);
            req_valid = 1'b1;
            @(negedge clk);
            check($sformatf("R%0d vec%0d", VEC[i][29:26], i),
                  {rsp_valid, exc_illegal, exc_virtual}, {1'b1, VEC[i][1:0]});
            n_chk++;
            if (exc_illegal && exc_virtual) begin // R2
                n_bad++;
                $display("FAIL R2 vec%0d: actual=11 expected=onehot0", i);
            end
        end

        // R1: an illegal-raising input without a request gives nothing
        drive(VEC[0]);
        req_valid = 1'b0;
        @(negedge clk);
        check("R1 no req", {rsp_valid, exc_illegal, exc_virtual}, 3'b000);

        // R7: every enable bit clear, gating disabled, scontext from VS is fine
        drive({4'd7,12'h5A8,1'b0,2'd1,1'b1,1'b1,1'b0,3'b000,2'b00,1'b1,2'b00});
        req_valid = 1'b1;
        @(negedge clk);
        check("R7 sen off VS", {rsp_valid, exc_illegal, exc_virtual}, 3'b100);

        // R3: VS form of an alias under hypervisor gate clear, m set
        drive({4'd3,12'h257,1'b0,2'd1,1'b1,1'b1,1'b1,3'b100,2'b00,1'b1,2'b01});
        @(negedge clk);
        check("R3 vsalias h", {rsp_valid, exc_illegal, exc_virtual}, 3'b101);

        // R9: 0x154 is not an alias, so a missing target has no effect
        drive({4'd9,12'h154,1'b0,2'd1,1'b0,1'b1,1'b1,3'b100,2'b00,1'b0,2'b00});
        @(negedge clk);
        check("R9 non-alias", {rsp_valid, exc_illegal, exc_virtual}, 3'b100);

        req_valid = 1'b0;
        @(negedge clk);
        check("R1 drop", {rsp_valid, exc_illegal, exc_virtual}, 3'b000);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule